// File: doc/BRIEF.md
# Serial Control Port with Read-Data Interrupt

This block is a serial slave port through which an external master writes configuration bytes into the core and reads bytes out of a pending-data queue. It runs entirely in the system clock domain. The serial clock, chip select and data-in pins pass through synchronizers, and the block acts on the detected rising edges of the serial clock. Every transaction begins with a falling chip select and a first byte that holds a 7-bit device address and a direction bit. Bits travel most significant bit first. On a write, each completed byte is presented to the core with a one-cycle strobe. On a read, bytes are popped from a first-word-fall-through queue and shifted out.

An active-low, open-drain interrupt line tells the master that read data is waiting. The block only ever pulls it low or lets it go. The serial protocol fixes how the line is released at the end of the last byte and when it may be asserted again. A re-assertion after the line has been released within a read is a request for a new read transaction. For the rest of the current transaction the block sends zeros, so no byte is lost.

Top module: `spi_ctl_port`

## Requirements
- R1: After reset, the data-out enable, the write strobe and the interrupt pull-down are all deasserted while the queue is empty.
- R2: When the first byte is {DEV_ADDR, 0}, each later complete byte is presented on wr_data_o with wr_valid_o high for exactly one cycle, in the order received.
- R3: When the 7-bit address in the first byte differs from DEV_ADDR, the rest of the transaction produces no write strobe and no pop, and the data-out enable stays low.
- R4: When the first byte is {DEV_ADDR, 1}, queue bytes are shifted out MSB first. The output changes after the serial clock rising edge and is stable at the next rising edge. Each byte pops the queue exactly once.
- R5: A read byte that finds the queue empty shifts out 0x00 and does not pop.
- R6: The data-out enable is high only during a read transaction to this address, and it drops after chip select rises.
- R7: Outside a read transaction, the interrupt pull-down follows whether the queue holds data.
- R8: During a read, at the rising edge for the second-to-last bit of a byte, the interrupt line is released if the queue is empty. If data remains, it stays asserted.
- R9: Once released, the interrupt line stays released until the next serial clock rising edge (or chip select rising). After that it is pulled low again if data is pending.
- R10: After a release within a read transaction, later bytes of that transaction shift out 0x00 without popping. The pending data is delivered by the next read transaction.
- R11: A byte cut short by chip select rising is discarded and does not affect the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from master |
| cs_ni | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data from master |
| sdo_o | output | 1 | Serial data to master |
| sdo_oe_o | output | 1 | Output enable for sdo_o (low = high impedance) |
| irq_pull_o | output | 1 | 1 = pull the open-drain interrupt line low, 0 = release |
| wr_data_o | output | 8 | Received write byte |
| wr_valid_o | output | 1 | One-cycle strobe for wr_data_o |
| rd_data_i | input | 8 | Head of the pending-data queue |
| rd_avail_i | input | 1 | Queue holds at least one byte |
| rd_pop_o | output | 1 | One-cycle pop of the queue head |

## Verification
Writes are sent with alternating and asymmetric byte values, so that bit order and byte order both show up in the received data. Reads are run against a queue holding two bytes, a queue that is empty, and a queue that empties during the transfer. This separates normal popping from the zero fill and from the interrupt release. Mismatched addresses in both directions, and a byte cut short by chip select, show that foreign or partial traffic leaves no trace. In the release test, data is pushed during the hold window. This tells apart an interrupt line that waits for the next serial clock edge from one that reacts at once.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } spi_st_e;
endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic sdi_i,
  output logic sck_rise_o,
  output logic cs_high_o,
  output logic cs_rise_o,
  output logic sdi_o
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] sck_q, cs_q, sdi_q;
  logic         sck_d, cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      cs_q  <= '1;
      sdi_q <= '0;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_q <= {sck_q[MSB-1:0], sck_i};
      cs_q  <= {cs_q[MSB-1:0], cs_ni};
      sdi_q <= {sdi_q[MSB-1:0], sdi_i};
      sck_d <= sck_q[MSB];
      cs_d  <= cs_q[MSB];
    end
  end

  assign sck_rise_o = sck_q[MSB] & ~sck_d;
  assign cs_high_o  = cs_q[MSB];
  assign cs_rise_o  = cs_q[MSB] & ~cs_d;
  assign sdi_o      = sdi_q[MSB];
endmodule

// File: rtl/spi_ctl_engine.sv
module spi_ctl_engine
  import spi_ctl_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              cs_high_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_avail_i,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  output logic              rd_pop_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              in_read_o,
  output logic              rel_o
);
  localparam int              CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] PENULT = CNT_W'(DATA_W - 2);

  spi_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_q, tx_q, rx_byte;
  logic              drained_q, load_ok;

  assign rx_byte = {rx_q[DATA_W-2:0], sdi_i};
  assign load_ok = rd_avail_i & ~drained_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      drained_q  <= 1'b0;
      wr_data_o  <= '0;
      wr_valid_o <= 1'b0;
      rd_pop_o   <= 1'b0;
      rel_o      <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      rd_pop_o   <= 1'b0;
      rel_o      <= 1'b0;
      if (cs_high_i) begin
        st_q      <= ST_IDLE;
        cnt_q     <= '0;
        drained_q <= 1'b0;
      end else if (st_q == ST_IDLE) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
      end else if (sck_rise_i) begin
        rx_q  <= rx_byte;
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        // release decision on the second-to-last bit
        if (st_q == ST_READ && cnt_q == PENULT && !rd_avail_i && !drained_q) begin
          rel_o     <= 1'b1;
          drained_q <= 1'b1;
        end
        if (cnt_q == LAST) begin
          tx_q <= '0;
          unique case (st_q)
            ST_ADDR: begin
              if (rx_byte[DATA_W-1 -: ADDR_W] != DEV_ADDR) st_q <= ST_SKIP;
              else if (!rx_byte[0]) st_q <= ST_WRITE;
              else begin
                st_q     <= ST_READ;
                tx_q     <= load_ok ? rd_data_i : '0;
                rd_pop_o <= load_ok;
              end
            end
            ST_WRITE: begin
              wr_data_o  <= rx_byte;
              wr_valid_o <= 1'b1;
            end
            ST_READ: begin
              tx_q     <= load_ok ? rd_data_i : '0;
              rd_pop_o <= load_ok;
            end
            default: ;
          endcase
        end else if (st_q == ST_READ) begin
          tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo_o     = tx_q[DATA_W-1];
  assign sdo_oe_o  = (st_q == ST_READ);
  assign in_read_o = (st_q == ST_READ);
endmodule

// File: rtl/spi_ctl_irq.sv
module spi_ctl_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_rise_i,
  input  logic cs_rise_i,
  input  logic rel_i,
  input  logic in_read_i,
  input  logic rd_avail_i,
  output logic irq_pull_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_pull_o <= 1'b0;
      hold_q     <= 1'b0;
    end else if (rel_i) begin
      irq_pull_o <= 1'b0;
      hold_q     <= 1'b1;
    end else if (hold_q) begin
      if (sck_rise_i || cs_rise_i) hold_q <= 1'b0;
    end else if (in_read_i) begin
      // inside a read only the release rule may let the line go
      irq_pull_o <= irq_pull_o | rd_avail_i;
    end else begin
      irq_pull_o <= rd_avail_i;
    end
  end
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port #(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 7,
  parameter int                STAGES   = 2,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              irq_pull_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_avail_i,
  output logic              rd_pop_o
);
  logic sck_rise, cs_high, cs_rise, sdi_s, in_read, rel;

  spi_ctl_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .sdi_i,
    .sck_rise_o(sck_rise), .cs_high_o(cs_high), .cs_rise_o(cs_rise), .sdi_o(sdi_s)
  );

  spi_ctl_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk_i, .rst_ni,
    .sck_rise_i(sck_rise), .cs_high_i(cs_high), .sdi_i(sdi_s),
    .rd_data_i, .rd_avail_i,
    .wr_data_o, .wr_valid_o, .rd_pop_o, .sdo_o, .sdo_oe_o,
    .in_read_o(in_read), .rel_o(rel)
  );

  spi_ctl_irq u_irq (
    .clk_i, .rst_ni,
    .sck_rise_i(sck_rise), .cs_rise_i(cs_rise), .rel_i(rel),
    .in_read_i(in_read), .rd_avail_i, .irq_pull_o
  );
endmodule

// File: rtl/spi_ctl_port_chk.sv
module spi_ctl_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_valid_o,
  input logic rd_pop_o,
  input logic rd_avail_i,
  input logic sdo_oe_o,
  input logic irq_pull_o,
  input logic cs_high,
  input logic rel
);
  // R2
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
  // R4
  single_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pop_o |=> !rd_pop_o);
  // R5
  no_empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pop_o |-> rd_avail_i);
  // R6
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_high |=> !sdo_oe_o);
  // R3
  dir_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !sdo_oe_o);
  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel |=> !irq_pull_o);
endmodule

bind spi_ctl_port spi_ctl_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_o(wr_valid_o), .rd_pop_o(rd_pop_o),
  .rd_avail_i(rd_avail_i), .sdo_oe_o(sdo_oe_o), .irq_pull_o(irq_pull_o),
  .cs_high(cs_high), .rel(rel)
);

// File: tb/tb_spi_ctl_port.sv
module tb_spi_ctl_port;
  localparam int HALF = 10;
  localparam logic [7:0] A_WR = {7'h2A, 1'b0};
  localparam logic [7:0] A_RD = {7'h2A, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, irq_pull, wr_valid, rd_pop, rd_avail;
  logic [7:0] wr_data, rd_data;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] q [16];
  int qh = 0, qt = 0, pops = 0;
  logic [7:0] wlog [32];
  int wn = 0;

  always #2.5 clk = ~clk;

  spi_ctl_port dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .irq_pull_o(irq_pull),
    .wr_data_o(wr_data), .wr_valid_o(wr_valid),
    .rd_data_i(rd_data), .rd_avail_i(rd_avail), .rd_pop_o(rd_pop)
  );

  assign rd_avail = (qh != qt);
  assign rd_data  = q[qh[3:0]];

  always @(posedge clk) begin
    if (rd_pop) begin qh <= qh + 1; pops <= pops + 1; end
    if (wr_valid) begin wlog[wn[4:0]] <= wr_data; wn <= wn + 1; end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v);
    q[qt[3:0]] = v;
    qt = qt + 1;
  endtask

  task automatic cs_start();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    sck  = 1'b0;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i]; sck = 1'b0;
      repeat (HALF) @(negedge clk);
      rx[i] = sdo;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(sdo_oe == 1'b0, "R1 oe", int'(sdo_oe), 0);
    chk(wr_valid == 1'b0, "R1 strobe", int'(wr_valid), 0);
    chk(irq_pull == 1'b0, "R1 irq", int'(irq_pull), 0);
  endtask

  task automatic t_write();
    logic [7:0] r;
    int w0 = wn;
    cs_start(); xfer(A_WR, r); xfer(8'hA5, r); xfer(8'h3C, r); cs_end();
    chk(wn - w0 == 2, "R2 count", wn - w0, 2);
    chk(wlog[w0[4:0]] == 8'hA5, "R2 byte0", int'(wlog[w0[4:0]]), 'hA5);
    chk(wlog[5'(w0+1)] == 8'h3C, "R2 byte1", int'(wlog[5'(w0+1)]), 'h3C);
  endtask

  task automatic t_partial();
    logic [7:0] r;
    int w0 = wn;
    cs_start(); xfer(A_WR, r);
    for (int i = 0; i < 4; i++) begin
      sdi = 1'b1; sck = 1'b0; repeat (HALF) @(negedge clk);
      sck = 1'b1; repeat (HALF) @(negedge clk);
    end
    cs_end();
    chk(wn == w0, "R11 no strobe", wn - w0, 0);
    cs_start(); xfer(A_WR, r); xfer(8'h81, r); cs_end();
    chk(wlog[w0[4:0]] == 8'h81, "R11 next byte", int'(wlog[w0[4:0]]), 'h81);
  endtask

  task automatic t_mismatch();
    logic [7:0] r;
    int w0 = wn, p0;
    push(8'h5A);
    p0 = pops;
    cs_start(); xfer({7'h13, 1'b0}, r); xfer(8'hFF, r); cs_end();
    chk(wn == w0, "R3 write ignored", wn - w0, 0);
    cs_start(); xfer({7'h2B, 1'b1}, r);
    repeat (HALF) @(negedge clk);
    chk(sdo_oe == 1'b0, "R3 oe", int'(sdo_oe), 0);
    xfer(8'h00, r); cs_end();
    chk(pops == p0, "R3 no pop", pops - p0, 0);
  endtask

  task automatic t_read();
    logic [7:0] r;
    int p0;
    push(8'hC3);
    chk(irq_pull == 1'b1, "R7 pending", int'(irq_pull), 1);
    p0 = pops;
    cs_start(); xfer(A_RD, r);
    repeat (HALF) @(negedge clk);
    chk(sdo_oe == 1'b1, "R6 oe on", int'(sdo_oe), 1);
    xfer(8'h00, r);
    chk(r == 8'h5A, "R4 byte0", int'(r), 'h5A);
    chk(irq_pull == 1'b1, "R8 kept while data", int'(irq_pull), 1);
    xfer(8'h00, r);
    chk(r == 8'hC3, "R4 byte1", int'(r), 'hC3);
    cs_end();
    chk(pops - p0 == 2, "R4 pops", pops - p0, 2);
    chk(sdo_oe == 1'b0, "R6 oe off", int'(sdo_oe), 0);
    chk(irq_pull == 1'b0, "R7 empty", int'(irq_pull), 0);
  endtask

  task automatic t_empty();
    logic [7:0] r;
    int p0 = pops;
    cs_start(); xfer(A_RD, r); xfer(8'h00, r); cs_end();
    chk(r == 8'h00, "R5 zero", int'(r), 0);
    chk(pops == p0, "R5 no pop", pops - p0, 0);
  endtask

  task automatic t_irq();
    logic [7:0] r;
    int p0;
    push(8'h96);
    repeat (4) @(negedge clk);
    chk(irq_pull == 1'b1, "R7 asserted", int'(irq_pull), 1);
    cs_start(); xfer(A_RD, r);
    for (int i = 7; i >= 0; i--) begin
      sdi = 1'b0; sck = 1'b0;
      repeat (HALF) @(negedge clk);
      r[i] = sdo;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i == 1) begin
        chk(irq_pull == 1'b0, "R8 released", int'(irq_pull), 0);
        push(8'h77);
        repeat (2) @(negedge clk);
        chk(irq_pull == 1'b0, "R9 held", int'(irq_pull), 0);
      end
    end
    chk(irq_pull == 1'b1, "R9 reasserted", int'(irq_pull), 1);
    chk(r == 8'h96, "R4 last byte", int'(r), 'h96);
    p0 = pops;
    xfer(8'h00, r);
    chk(r == 8'h00, "R10 zero fill", int'(r), 0);
    chk(pops == p0, "R10 no pop", pops - p0, 0);
    cs_end();
    cs_start(); xfer(A_RD, r); xfer(8'h00, r); cs_end();
    chk(r == 8'h77, "R10 next read", int'(r), 'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write();
    t_partial();
    t_mismatch();
    t_read();
    t_empty();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule